// File: doc/BRIEF.md
# Shared-Temp 16-bit Register Access Unit

This block puts a bank of 16-bit timer registers behind a byte-wide synchronous bus. Register 0 is a free-running count register, and register 1 is a period register. Each 16-bit register takes two byte addresses. A single temporary byte, shared by every register in the bank, lets software move a full 16-bit value in one indivisible step. For a write, the low byte is parked in the temporary byte, and the high-byte write then commits both halves in the same clock. For a read, the low-byte read captures the high half into the temporary byte, so the high-byte read that follows returns a value taken at the same instant as the low byte.

Because the temporary byte is shared, one 16-bit access placed between the two halves of another one corrupts the outer access. Software must guard against this. When the debug-halt input is high, the temporary byte is bypassed: every byte of every register can be read and written directly. In this mode the temporary byte appears at an address of its own.

Each bus cycle is classified into one access kind by a combinational decode: idle, low write, high write, low read, high read, temp write, temp read, or void read. The temporary byte, the register bank and the read-data register each act on that kind.

Top module: `tmp16_access_unit`

## Requirements
- R1: After reset, every 16-bit register, the temporary byte and the read data are zero.
- R2: Outside debug-halt, a write to a low-byte address (register i low byte at address 2*i) loads only the temporary byte. The addressed register keeps its value.
- R3: Outside debug-halt, a write to a high-byte address (2*i+1) sets register i to {write data, temporary byte} in that same clock.
- R4: The temporary byte is shared. A low-byte write to another register between the two halves of a write changes the low byte that the next high-byte write commits.
- R5: Outside debug-halt, a low-byte read returns the live low byte and copies the live high byte into the temporary byte. A high-byte read returns the temporary byte.
- R6: In debug-halt, low-byte and high-byte accesses read and write the addressed register byte directly, and the temporary byte is left unchanged.
- R7: In debug-halt, the temporary byte can be read and written at address 2*NUM_REGS.
- R8: Outside debug-halt, a read of address 2*NUM_REGS returns zero, and a write to it has no effect.
- R9: Register 0 increments by one on each clock with the count enable high. Any write that changes register 0 in that clock (a high-byte write, or a low-byte write in debug-halt) takes priority over the increment.
- R10: Read data is registered and appears the clock after a read strobe. When both strobes are high, the write is done and the read is dropped. Read data holds its value when no read is performed. Addresses above 2*NUM_REGS read as zero and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dbg_halt | input | 1 | Debug-halt: bypass the temporary byte and expose it directly |
| cnt_en | input | 1 | Count enable for register 0 |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 8 | Write data |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 8 | Registered read data |

## Verification
The bench interleaves a period low-byte write between the two halves of a count write. A design with a separate holding byte per register would commit the original low byte instead of the overwritten one. It reads the count register while it is incrementing across a carry from 0x00FF. A design that returned the live high byte would report 0x01 instead of the 0x00 snapshot. It drives a high-byte write while counting is enabled, which catches any design that lets the increment win. It also checks that debug-halt accesses leave the temporary byte alone, that the temporary address is inert outside debug-halt, and that the read data holds when the read strobe is idle or shares a cycle with a write.

// File: rtl/tmp16_pkg.sv
package tmp16_pkg;
    localparam int BYTE_W = 8;
    localparam int WORD_W = 16;

    typedef enum logic [2:0] {
        ACC_NONE,
        ACC_LO_WR,
        ACC_HI_WR,
        ACC_LO_RD,
        ACC_HI_RD,
        ACC_TMP_WR,
        ACC_TMP_RD,
        ACC_VOID_RD
    } acc_kind_e;

    typedef enum logic [1:0] {
        ZONE_REG,
        ZONE_TEMP,
        ZONE_VOID
    } addr_zone_e;
endpackage

// File: rtl/tmp16_decode.sv
module tmp16_decode
    import tmp16_pkg::*;
#(
    parameter int NUM_REGS = 2,
    parameter int ADDR_W   = 3,
    parameter int IDX_W    = 1
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr,
    input  logic              rd,
    input  logic              halt,
    output acc_kind_e         kind,
    output logic [IDX_W-1:0]  idx
);
    localparam logic [ADDR_W-1:0] TEMP_ADDR = ADDR_W'(2 * NUM_REGS);

    addr_zone_e zone;

    always_comb begin
        idx = IDX_W'(addr >> 1);
        if (addr < TEMP_ADDR)       zone = ZONE_REG;
        else if (addr == TEMP_ADDR) zone = ZONE_TEMP;
        else                        zone = ZONE_VOID;
    end

    always_comb begin
        kind = ACC_NONE;
        unique case (zone)
            ZONE_REG: begin
                if (wr)      kind = addr[0] ? ACC_HI_WR : ACC_LO_WR;
                else if (rd) kind = addr[0] ? ACC_HI_RD : ACC_LO_RD;
            end
            ZONE_TEMP: begin
                if (wr)      kind = halt ? ACC_TMP_WR : ACC_NONE;
                else if (rd) kind = halt ? ACC_TMP_RD : ACC_VOID_RD;
            end
            ZONE_VOID: begin
                if (!wr && rd) kind = ACC_VOID_RD;
            end
            default: kind = ACC_NONE;
        endcase
    end
endmodule

// File: rtl/tmp16_temp.sv
module tmp16_temp
    import tmp16_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              halt,
    input  acc_kind_e         kind,
    input  logic [BYTE_W-1:0] wdata,
    input  logic [BYTE_W-1:0] live_hi,
    output logic [BYTE_W-1:0] temp_q
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            temp_q <= '0;
        end else if (halt) begin
            if (kind == ACC_TMP_WR) temp_q <= wdata;
        end else begin
            unique case (kind)
                ACC_LO_WR: temp_q <= wdata;
                ACC_LO_RD: temp_q <= live_hi;
                default:   temp_q <= temp_q;
            endcase
        end
    end
endmodule

// File: rtl/tmp16_regbank.sv
module tmp16_regbank
    import tmp16_pkg::*;
#(
    parameter int NUM_REGS = 2,
    parameter int IDX_W    = 1,
    parameter int CNT_IDX  = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              halt,
    input  logic              cnt_en,
    input  acc_kind_e         kind,
    input  logic [IDX_W-1:0]  idx,
    input  logic [BYTE_W-1:0] wdata,
    input  logic [BYTE_W-1:0] temp_q,
    output logic [WORD_W-1:0] regs [NUM_REGS]
);
    for (genvar g = 0; g < NUM_REGS; g++) begin : g_word
        logic [WORD_W-1:0] word_q;
        logic              hit;

        assign hit     = (idx == IDX_W'(g));
        assign regs[g] = word_q;

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                word_q <= '0;
            end else if (hit && kind == ACC_HI_WR) begin
                word_q <= halt ? {wdata, word_q[BYTE_W-1:0]} : {wdata, temp_q};
            end else if (hit && kind == ACC_LO_WR && halt) begin
                word_q[BYTE_W-1:0] <= wdata;
            end else if (g == CNT_IDX && cnt_en) begin
                word_q <= word_q + WORD_W'(1);
            end
        end
    end
endmodule

// File: rtl/tmp16_access_unit.sv
module tmp16_access_unit
    import tmp16_pkg::*;
#(
    parameter int NUM_REGS = 2,
    parameter int ADDR_W   = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              dbg_halt,
    input  logic              cnt_en,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [7:0]        bus_wdata,
    input  logic              bus_wr,
    input  logic              bus_rd,
    output logic [7:0]        bus_rdata
);
    localparam int IDX_W = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;

    acc_kind_e         kind;
    logic [IDX_W-1:0]  idx;
    logic [BYTE_W-1:0] temp_q;
    logic [WORD_W-1:0] regs [NUM_REGS];
    logic [WORD_W-1:0] sel_word;

    tmp16_decode #(.NUM_REGS(NUM_REGS), .ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_decode (
        .addr (bus_addr),
        .wr   (bus_wr),
        .rd   (bus_rd),
        .halt (dbg_halt),
        .kind (kind),
        .idx  (idx)
    );

    assign sel_word = regs[idx];

    tmp16_temp u_temp (
        .clk     (clk),
        .rst_n   (rst_n),
        .halt    (dbg_halt),
        .kind    (kind),
        .wdata   (bus_wdata),
        .live_hi (sel_word[WORD_W-1:BYTE_W]),
        .temp_q  (temp_q)
    );

    tmp16_regbank #(.NUM_REGS(NUM_REGS), .IDX_W(IDX_W), .CNT_IDX(0)) u_bank (
        .clk    (clk),
        .rst_n  (rst_n),
        .halt   (dbg_halt),
        .cnt_en (cnt_en),
        .kind   (kind),
        .idx    (idx),
        .wdata  (bus_wdata),
        .temp_q (temp_q),
        .regs   (regs)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_rdata <= '0;
        end else begin
            unique case (kind)
                ACC_LO_RD:   bus_rdata <= sel_word[BYTE_W-1:0];
                ACC_HI_RD:   bus_rdata <= dbg_halt ? sel_word[WORD_W-1:BYTE_W] : temp_q;
                ACC_TMP_RD:  bus_rdata <= temp_q;
                ACC_VOID_RD: bus_rdata <= '0;
                default:     bus_rdata <= bus_rdata;
            endcase
        end
    end
endmodule

// File: rtl/tmp16_access_chk.sv
module tmp16_access_chk #(
    parameter int NUM_REGS = 2,
    parameter int ADDR_W   = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              dbg_halt,
    input logic              cnt_en,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [7:0]        bus_wdata,
    input logic              bus_wr,
    input logic              bus_rd,
    input logic [7:0]        bus_rdata,
    input logic [7:0]        temp_q,
    input logic [15:0]       regs [NUM_REGS]
);
    localparam logic [ADDR_W-1:0] TEMP_ADDR = ADDR_W'(2 * NUM_REGS);
    localparam logic [ADDR_W-1:0] CNT_LO    = ADDR_W'(0);
    localparam logic [ADDR_W-1:0] CNT_HI    = ADDR_W'(1);

    logic lo_any;
    logic cnt_write;

    assign lo_any    = (bus_addr < TEMP_ADDR) && !bus_addr[0];
    assign cnt_write = bus_wr && (bus_addr == CNT_HI || (dbg_halt && bus_addr == CNT_LO));

    AST_LO_WR_TEMP: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && !dbg_halt && lo_any) |=> temp_q == $past(bus_wdata)); // R2

    for (genvar j = 0; j < NUM_REGS; j++) begin : g_chk
        localparam logic [ADDR_W-1:0] LO_A = ADDR_W'(2 * j);
        localparam logic [ADDR_W-1:0] HI_A = ADDR_W'(2 * j + 1);

        AST_LO_WR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
            (bus_wr && !dbg_halt && bus_addr == LO_A && (j != 0 || !cnt_en)) |=> $stable(regs[j])); // R2

        AST_HI_WR_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
            (bus_wr && !dbg_halt && bus_addr == HI_A) |=> regs[j] == {$past(bus_wdata), $past(temp_q)}); // R3
    end

    AST_HALT_TEMP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (dbg_halt && (bus_wr || bus_rd) && bus_addr != TEMP_ADDR) |=> $stable(temp_q)); // R6

    AST_TEMP_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && !bus_wr && !dbg_halt && bus_addr == TEMP_ADDR) |=> bus_rdata == 8'h00); // R8

    AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_en && !cnt_write) |=> regs[0] == $past(regs[0]) + 16'd1); // R9

    AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_rd || bus_wr) |=> $stable(bus_rdata)); // R10
endmodule

bind tmp16_access_unit tmp16_access_chk #(.NUM_REGS(NUM_REGS), .ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .dbg_halt  (dbg_halt),
    .cnt_en    (cnt_en),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_rdata (bus_rdata),
    .temp_q    (temp_q),
    .regs      (regs)
);

// File: tb/tmp16_access_unit_bench.sv
module tmp16_access_unit_bench;
    localparam int ADDR_W = 3;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              dbg_halt = 1'b0;
    logic              cnt_en = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic [7:0]        bus_wdata = '0;
    logic              bus_wr = 1'b0;
    logic              bus_rd = 1'b0;
    logic [7:0]        bus_rdata;

    int    checks = 0;
    int    errors = 0;
    bit    done = 1'b0;
    logic  rd_fire = 1'b0;
    logic [7:0] exp_q [$];
    string      tag_q [$];

    always #5 clk = ~clk;

    tmp16_access_unit #(.NUM_REGS(2), .ADDR_W(ADDR_W)) u_tmp16_access_unit (
        .clk       (clk),
        .rst_n     (rst_n),
        .dbg_halt  (dbg_halt),
        .cnt_en    (cnt_en),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_rdata (bus_rdata)
    );

    task automatic check(input logic [7:0] act, input logic [7:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [ADDR_W-1:0] a, input logic [7:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [ADDR_W-1:0] a, input logic [7:0] exp, input string tag);
        bus_addr = a; bus_rd = 1'b1;
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    // monitor: a read sampled at a rising edge is compared at the following falling edge
    always @(posedge clk) rd_fire <= rst_n && bus_rd && !bus_wr;

    always @(negedge clk) begin
        if (rd_fire) begin
            if (exp_q.size() == 0) begin
                checks++; errors++;
                $display("FAIL R10: unexpected read data actual=%02h expected=none", bus_rdata);
            end else begin
                check(bus_rdata, exp_q.pop_front(), tag_q.pop_front());
            end
        end
    end

    task automatic summary;
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            checks++; errors++;
            $display("FAIL R10: watchdog expired actual=hung expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        check(bus_rdata, 8'h00, "R1 rdata reset");
        dbg_halt = 1'b1;
        for (int i = 0; i < 5; i++) rd(ADDR_W'(i), 8'h00, "R1 reset value");

        // low write parks in temp only, high write commits
        dbg_halt = 1'b0; wr(3'd2, 8'h34);
        dbg_halt = 1'b1;
        rd(3'd2, 8'h00, "R2 low held back"); rd(3'd3, 8'h00, "R2 high untouched");
        rd(3'd4, 8'h34, "R2 temp loaded");
        dbg_halt = 1'b0; wr(3'd3, 8'h12);
        dbg_halt = 1'b1;
        rd(3'd2, 8'h34, "R3 commit low"); rd(3'd3, 8'h12, "R3 commit high");

        // interleaved access corrupts the shared temp
        dbg_halt = 1'b0;
        wr(3'd0, 8'hAA); wr(3'd2, 8'h55); wr(3'd1, 8'hBB); wr(3'd3, 8'h66);
        dbg_halt = 1'b1;
        rd(3'd0, 8'h55, "R4 count low corrupted"); rd(3'd1, 8'hBB, "R4 count high");
        rd(3'd2, 8'h55, "R4 period low"); rd(3'd3, 8'h66, "R4 period high");

        // snapshot read across a carry
        dbg_halt = 1'b0;
        wr(3'd0, 8'hFF); wr(3'd1, 8'h00);
        cnt_en = 1'b1;
        rd(3'd0, 8'hFF, "R5 live low");
        rd(3'd1, 8'h00, "R5 snapshot high");
        cnt_en = 1'b0;
        dbg_halt = 1'b1;
        rd(3'd0, 8'h01, "R9 count low after 2"); rd(3'd1, 8'h01, "R9 count high after 2");

        // commit wins over increment, then free counting
        dbg_halt = 1'b0;
        wr(3'd0, 8'h10);
        cnt_en = 1'b1;
        wr(3'd1, 8'h20);
        repeat (4) @(negedge clk);
        cnt_en = 1'b0;
        dbg_halt = 1'b1;
        rd(3'd0, 8'h14, "R9 priority low"); rd(3'd1, 8'h20, "R9 priority high");

        // debug-halt direct access
        wr(3'd4, 8'h77); wr(3'd2, 8'h9A); wr(3'd3, 8'hBC);
        rd(3'd2, 8'h9A, "R6 direct low"); rd(3'd3, 8'hBC, "R6 direct high");
        rd(3'd0, 8'h14, "R6 direct read");
        rd(3'd4, 8'h77, "R7 temp kept");

        // temp address inert in normal mode
        dbg_halt = 1'b0; wr(3'd4, 8'hEE);
        rd(3'd4, 8'h00, "R8 temp reads zero");
        dbg_halt = 1'b1; rd(3'd4, 8'h77, "R8 temp write ignored");

        // unmapped addresses, hold and strobe collision
        rd(3'd5, 8'h00, "R10 unmapped 5"); rd(3'd7, 8'h00, "R10 unmapped 7");
        wr(3'd6, 8'hFF);
        rd(3'd2, 8'h9A, "R10 write 6 ignored"); rd(3'd3, 8'hBC, "R10 write 6 ignored");
        rd(3'd4, 8'h77, "R10 temp after write 6");
        dbg_halt = 1'b0; rd(3'd6, 8'h00, "R10 unmapped normal");
        dbg_halt = 1'b1; rd(3'd2, 8'h9A, "R10 before hold");
        repeat (2) @(negedge clk);
        check(bus_rdata, 8'h9A, "R10 idle hold");
        bus_addr = 3'd4; bus_wdata = 8'h11; bus_wr = 1'b1; bus_rd = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0; bus_rd = 1'b0;
        check(bus_rdata, 8'h9A, "R10 collision hold");
        rd(3'd4, 8'h11, "R10 collision write done");

        repeat (3) @(negedge clk);
        if (exp_q.size() != 0) begin
            checks++; errors++;
            $display("FAIL R10: pending reads actual=%0d expected=0", exp_q.size());
        end
        done = 1'b1;
        summary();
        $finish;
    end
endmodule